// File: doc/BRIEF.md
# Mailbox Message Timestamp Unit

This block keeps a free-running 32-bit time counter that advances once per CAN bit time. It runs entirely in the fast system clock domain. The bit-timing logic supplies a one-cycle strobe for each elapsed bit. When the protocol engine reports a completed event, the block latches the counter value in that same cycle. There are two kinds of event: a transmission that reached its ACK delimiter, and a reception whose data bytes are all stored in a mailbox. The latched value is then written into the 32-bit timestamp register that belongs to the mailbox named with the event.

The timestamp registers sit behind a register port shared with the protocol engine, and the engine has priority on it. While the engine holds the port, latched events wait in a short ordered queue. Because each value was captured at event time, a late write still stores the event-time count. The wait never stalls the counter.

An enable input turns on auto-clear. With auto-clear on, any completed event on mailbox 16 resets the counter to zero. A plain CPU port reads the counter or any mailbox timestamp, and it can load the counter while no event is waiting.

Top module: `msg_stamp_unit`

## Requirements
- R1: The counter is 32 bits, resets to 0, and rises by exactly one on every cycle with `bit_tick` high. It wraps from 0xFFFFFFFF to 0 with no flag and no effect on `ovf_flag`. With no tick, no clear and no accepted load, it holds its value.
- R2: When `tx_done` is high, the counter value of that same cycle (before any increment) becomes the timestamp of mailbox `tx_mbox`.
- R3: When `rx_done` is high, the counter value of that same cycle becomes the timestamp of mailbox `rx_mbox`.
- R4: While `eng_busy` is high, no timestamp is written and the counter keeps counting ticks. Once `eng_busy` falls, each waiting event is written, one per cycle, with the value captured at its event time.
- R5: With `autoclr_en` high, a `tx_done` or `rx_done` on mailbox 16 forces the counter to 0 in the next cycle, even if `bit_tick` is high. Mailbox 16 records the value from before the clear. With `autoclr_en` low, such an event does not clear the counter.
- R6: Up to 4 events wait in arrival order. In one cycle, a transmit event is ordered before a receive event, so for the same mailbox the later event's value remains. An event that finds the queue full is dropped and sets `ovf_flag`, which stays high until reset.
- R7: A write with `cpu_wr`=1 and `cpu_sel`=0 loads `cpu_wdata` into the counter, taking priority over a tick. The load happens only if no event is waiting and no event arrives in that cycle. Otherwise the write is ignored.
- R8: `cpu_rdata` is the counter when `cpu_sel`=0. When `cpu_sel`=1, it is the timestamp of mailbox `cpu_addr`. A timestamp written at edge k can be read after edge k.
- R9: A synchronous reset clears the counter, every mailbox timestamp, the queue and `ovf_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe per CAN bit time |
| tx_done | input | 1 | Transmit reached ACK delimiter successfully |
| tx_mbox | input | 5 | Mailbox of the transmit event |
| rx_done | input | 1 | Received data fully stored |
| rx_mbox | input | 5 | Mailbox of the receive event |
| eng_busy | input | 1 | Protocol engine holds the shared register port |
| autoclr_en | input | 1 | Enables counter clear on mailbox 16 events |
| cpu_wr | input | 1 | CPU write strobe (counter only) |
| cpu_sel | input | 1 | 0: counter, 1: mailbox timestamp |
| cpu_addr | input | 5 | Mailbox index for reads |
| cpu_wdata | input | 32 | Counter load value |
| cpu_rdata | output | 32 | Read data |
| ovf_flag | output | 1 | Sticky event-queue overflow |

## Verification
The hardest situation to reach is a queue with several events waiting, captured at different counts, while the counter keeps moving. Only a held `eng_busy` creates it. The stimulus holds the port busy while ticks and paired transmit/receive events arrive, and it reuses one mailbox so that the arrival order is visible. It then fills the queue past four entries and attempts a counter load while the events are still waiting. After the port is released, every mailbox is read back and compared with the counts captured at event time.

// File: rtl/msu_pkg.sv
package msu_pkg;
    localparam int TS_W = 32;
    localparam int MB_N = 32;
    localparam int MB_W = $clog2(MB_N);

    typedef struct packed {
        logic [MB_W-1:0] mbox;
        logic [TS_W-1:0] stamp;
    } stamp_evt_t;
endpackage

// File: rtl/msu_counter.sv
module msu_counter
    import msu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            clr,
    input  logic            ld,
    input  logic [TS_W-1:0] ld_val,
    output logic [TS_W-1:0] cnt
);
    typedef struct packed {
        logic [TS_W-1:0] value;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.value = '0;
        end else if (ld) begin
            s_d.value = ld_val;
        end else if (tick) begin
            s_d.value = s_q.value + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cnt = s_q.value;
endmodule

// File: rtl/msu_queue.sv
module msu_queue
    import msu_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push_a,
    input  stamp_evt_t item_a,
    input  logic       push_b,
    input  stamp_evt_t item_b,
    input  logic       pop,
    output stamp_evt_t head,
    output logic       nonempty,
    output logic       ovf
);
    localparam int PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

    typedef struct packed {
        stamp_evt_t [DEPTH-1:0] slot;
        logic [PW-1:0]          rd;
        logic [PW-1:0]          wr;
        logic [PW:0]            count;
        logic                   ovf;
    } q_state_t;

    q_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pop && s_q.count != '0) begin
            s_d.rd    = (int'(s_q.rd) == DEPTH - 1) ? '0 : s_q.rd + 1'b1;
            s_d.count = s_d.count - 1'b1;
        end
        if (push_a) begin
            if (int'(s_d.count) < DEPTH) begin
                s_d.slot[s_d.wr] = item_a;
                s_d.wr    = (int'(s_d.wr) == DEPTH - 1) ? '0 : s_d.wr + 1'b1;
                s_d.count = s_d.count + 1'b1;
            end else begin
                s_d.ovf = 1'b1;
            end
        end
        if (push_b) begin
            if (int'(s_d.count) < DEPTH) begin
                s_d.slot[s_d.wr] = item_b;
                s_d.wr    = (int'(s_d.wr) == DEPTH - 1) ? '0 : s_d.wr + 1'b1;
                s_d.count = s_d.count + 1'b1;
            end else begin
                s_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign head     = s_q.slot[s_q.rd];
    assign nonempty = (s_q.count != '0);
    assign ovf      = s_q.ovf;
endmodule

// File: rtl/msu_store.sv
module msu_store
    import msu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [MB_W-1:0] wr_addr,
    input  logic [TS_W-1:0] wr_data,
    input  logic [MB_W-1:0] rd_addr,
    output logic [TS_W-1:0] rd_data
);
    logic [TS_W-1:0] mem_d [MB_N];
    logic [TS_W-1:0] mem_q [MB_N];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MB_N; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/msg_stamp_unit.sv
module msg_stamp_unit
    import msu_pkg::*;
#(
    parameter int QDEPTH   = 4,
    parameter int CLR_MBOX = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_tick,
    input  logic            tx_done,
    input  logic [MB_W-1:0] tx_mbox,
    input  logic            rx_done,
    input  logic [MB_W-1:0] rx_mbox,
    input  logic            eng_busy,
    input  logic            autoclr_en,
    input  logic            cpu_wr,
    input  logic            cpu_sel,
    input  logic [MB_W-1:0] cpu_addr,
    input  logic [TS_W-1:0] cpu_wdata,
    output logic [TS_W-1:0] cpu_rdata,
    output logic            ovf_flag
);
    localparam logic [MB_W-1:0] CLR_IDX = MB_W'(CLR_MBOX);

    logic [TS_W-1:0] cnt_val;
    logic [TS_W-1:0] st_rdata;
    logic            clr_hit;
    logic            cnt_ld;
    logic            q_pop;
    logic            q_nonempty;
    stamp_evt_t      q_head;
    stamp_evt_t      tx_item;
    stamp_evt_t      rx_item;

    always_comb begin
        clr_hit = autoclr_en && ((tx_done && tx_mbox == CLR_IDX) ||
                                 (rx_done && rx_mbox == CLR_IDX));
        cnt_ld  = cpu_wr && !cpu_sel && !q_nonempty && !tx_done && !rx_done;
        q_pop   = q_nonempty && !eng_busy;
        tx_item = '{mbox: tx_mbox, stamp: cnt_val};
        rx_item = '{mbox: rx_mbox, stamp: cnt_val};
    end

    msu_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (bit_tick),
        .clr    (clr_hit),
        .ld     (cnt_ld),
        .ld_val (cpu_wdata),
        .cnt    (cnt_val)
    );

    msu_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push_a   (tx_done),
        .item_a   (tx_item),
        .push_b   (rx_done),
        .item_b   (rx_item),
        .pop      (q_pop),
        .head     (q_head),
        .nonempty (q_nonempty),
        .ovf      (ovf_flag)
    );

    msu_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (q_pop),
        .wr_addr (q_head.mbox),
        .wr_data (q_head.stamp),
        .rd_addr (cpu_addr),
        .rd_data (st_rdata)
    );

    assign cpu_rdata = cpu_sel ? st_rdata : cnt_val;
endmodule

// File: rtl/msu_checker.sv
module msu_checker
    import msu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            bit_tick,
    input logic            tx_done,
    input logic [MB_W-1:0] tx_mbox,
    input logic            rx_done,
    input logic [MB_W-1:0] rx_mbox,
    input logic            autoclr_en,
    input logic            eng_busy,
    input logic            cpu_wr,
    input logic            cpu_sel,
    input logic [TS_W-1:0] cnt,
    input logic            st_wr,
    input logic            q_nonempty,
    input logic            ovf
);
    logic clr_evt;
    logic ld_try;
    assign clr_evt = autoclr_en && ((tx_done && tx_mbox == 5'd16) || (rx_done && rx_mbox == 5'd16));
    assign ld_try  = cpu_wr && !cpu_sel;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && !clr_evt && !ld_try) |=> cnt == $past(cnt) + 32'd1); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bit_tick && !clr_evt && !ld_try) |=> $stable(cnt)); // R1
    AST_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
        clr_evt |=> cnt == '0); // R5
    AST_BUSY_DEFER: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> !st_wr); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf); // R6
    AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (ld_try && q_nonempty && !bit_tick && !clr_evt) |=> $stable(cnt)); // R7
endmodule

bind msg_stamp_unit msu_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .tx_done    (tx_done),
    .tx_mbox    (tx_mbox),
    .rx_done    (rx_done),
    .rx_mbox    (rx_mbox),
    .autoclr_en (autoclr_en),
    .eng_busy   (eng_busy),
    .cpu_wr     (cpu_wr),
    .cpu_sel    (cpu_sel),
    .cnt        (cnt_val),
    .st_wr      (q_pop),
    .q_nonempty (q_nonempty),
    .ovf        (ovf_flag)
);

// File: tb/msg_stamp_unit_test.sv
module msg_stamp_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, bit_tick, tx_done, rx_done, eng_busy, autoclr_en;
    logic [4:0]  tx_mbox, rx_mbox, cpu_addr;
    logic        cpu_wr, cpu_sel;
    logic [31:0] cpu_wdata, cpu_rdata;
    logic        ovf_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [4:0]  m;
        logic [31:0] v;
    } exp_t;
    exp_t sb[$];

    logic [31:0] m_cnt;
    int          m_occ;
    logic        m_ovf;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msg_stamp_unit uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_done(tx_done), .tx_mbox(tx_mbox),
        .rx_done(rx_done), .rx_mbox(rx_mbox), .eng_busy(eng_busy), .autoclr_en(autoclr_en),
        .cpu_wr(cpu_wr), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // driver: one cycle, pushes expected stamps into the scoreboard
    task automatic cyc(input logic tk, input logic tv, input logic [4:0] tm,
                       input logic rv, input logic [4:0] rm);
        logic clr;
        int   occ;
        bit_tick = tk; tx_done = tv; tx_mbox = tm; rx_done = rv; rx_mbox = rm;
        clr = autoclr_en && ((tv && tm == 5'd16) || (rv && rm == 5'd16));
        occ = m_occ;
        if (occ > 0 && !eng_busy) occ--;
        if (tv) begin
            if (occ < 4) begin sb.push_back('{tm, m_cnt}); occ++; end
            else m_ovf = 1'b1;
        end
        if (rv) begin
            if (occ < 4) begin sb.push_back('{rm, m_cnt}); occ++; end
            else m_ovf = 1'b1;
        end
        m_occ = occ;
        if (clr) m_cnt = 32'd0;
        else if (tk) m_cnt = m_cnt + 32'd1;
        @(posedge clk); #1;
        bit_tick = 0; tx_done = 0; rx_done = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 5'd0, 1'b0, 5'd0);
    endtask

    task automatic wr_cnt(input logic [31:0] v, input logic tk);
        cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_wdata = v; bit_tick = tk;
        if (m_occ == 0) m_cnt = v;
        else if (tk) m_cnt = m_cnt + 32'd1;
        if (m_occ > 0 && !eng_busy) m_occ--;
        @(posedge clk); #1;
        cpu_wr = 1'b0; bit_tick = 1'b0;
    endtask

    task automatic rd_cnt(output logic [31:0] v);
        cpu_sel = 1'b0; #1; v = cpu_rdata;
    endtask

    task automatic rd_ts(input logic [4:0] m, output logic [31:0] v);
        cpu_sel = 1'b1; cpu_addr = m; #1; v = cpu_rdata; cpu_sel = 1'b0;
    endtask

    // monitor: pops expected stamps and compares against the stored ones
    task automatic drain_check(input string req);
        logic [31:0] v;
        while (sb.size() > 0) begin
            exp_t e;
            bit   later;
            e = sb.pop_front();
            later = 0;
            foreach (sb[j]) if (sb[j].m == e.m) later = 1;
            if (!later) begin
                rd_ts(e.m, v);
                chk(v == e.v, req, v, e.v);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, base;
        rst = 1; bit_tick = 0; tx_done = 0; rx_done = 0; tx_mbox = 0; rx_mbox = 0;
        eng_busy = 0; autoclr_en = 0; cpu_wr = 0; cpu_sel = 0; cpu_addr = 0; cpu_wdata = 0;
        m_cnt = 0; m_occ = 0; m_ovf = 0;
        repeat (3) @(posedge clk); #1;
        rst = 0;

        // R9 reset state
        rd_cnt(v);  chk(v == 0, "R9 counter", v, 0);
        rd_ts(5'd5, v); chk(v == 0, "R9 ts5", v, 0);
        chk(ovf_flag == 0, "R9 ovf", {31'd0, ovf_flag}, 0);

        // R1 counting
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 5'd0, 1'b0, 5'd0);
        idle(2);
        rd_cnt(v); chk(v == 32'd10, "R1 count", v, 32'd10);

        // R2 transmit capture coincident with tick
        cyc(1'b1, 1'b1, 5'd3, 1'b0, 5'd0);
        idle(2);
        drain_check("R2 tx stamp");
        // R3 receive capture
        cyc(1'b1, 1'b0, 5'd0, 1'b0, 5'd0);
        cyc(1'b0, 1'b0, 5'd0, 1'b1, 5'd7);
        idle(2);
        drain_check("R3 rx stamp");
        // R8 counter read after mailbox reads
        rd_cnt(v); chk(v == m_cnt, "R8 counter read", v, m_cnt);

        // R4 busy port: captures deferred, counting continues
        eng_busy = 1;
        rd_cnt(base);
        cyc(1'b1, 1'b1, 5'd1, 1'b0, 5'd0);
        cyc(1'b1, 1'b0, 5'd0, 1'b1, 5'd2);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 5'd0, 1'b0, 5'd0);
        rd_cnt(v); chk(v == base + 32'd6, "R4 count while busy", v, base + 32'd6);
        rd_ts(5'd1, v); chk(v == 0, "R4 no write while busy", v, 0);
        eng_busy = 0;
        idle(3);
        drain_check("R4 deferred stamp");

        // R5 auto-clear disabled, then enabled
        cyc(1'b1, 1'b1, 5'd16, 1'b0, 5'd0);
        idle(2);
        rd_cnt(v); chk(v == m_cnt && v != 0, "R5 no clear when disabled", v, m_cnt);
        drain_check("R5 ts16 disabled");
        autoclr_en = 1;
        cyc(1'b1, 1'b0, 5'd0, 1'b1, 5'd16);
        rd_cnt(v); chk(v == 0, "R5 clear beats tick", v, 0);
        idle(2);
        drain_check("R5 ts16 pre-clear value");
        autoclr_en = 0;

        // R6 ordering and overflow, R7 blocked load
        eng_busy = 1;
        cyc(1'b1, 1'b1, 5'd13, 1'b1, 5'd9);
        cyc(1'b1, 1'b1, 5'd10, 1'b1, 5'd13);
        cyc(1'b1, 1'b1, 5'd12, 1'b0, 5'd0);
        chk(ovf_flag == 1, "R6 overflow set", {31'd0, ovf_flag}, 1);
        rd_cnt(base);
        wr_cnt(32'hDEAD0000, 1'b0);
        rd_cnt(v); chk(v == base, "R7 load ignored while pending", v, base);
        eng_busy = 0;
        idle(5);
        drain_check("R6 arrival order");
        rd_ts(5'd12, v); chk(v == 0, "R6 dropped event", v, 0);
        chk(ovf_flag == 1, "R6 overflow sticky", {31'd0, ovf_flag}, 1);

        // R7 accepted load beats tick, R1 wrap
        wr_cnt(32'hFFFFFFFE, 1'b1);
        rd_cnt(v); chk(v == 32'hFFFFFFFE, "R7 load", v, 32'hFFFFFFFE);
        cyc(1'b1, 1'b0, 5'd0, 1'b0, 5'd0);
        cyc(1'b1, 1'b0, 5'd0, 1'b0, 5'd0);
        rd_cnt(v); chk(v == 0, "R1 wrap", v, 0);
        cyc(1'b1, 1'b1, 5'd20, 1'b0, 5'd0);
        idle(2);
        drain_check("R2 stamp after wrap");

        // R9 reset mid-run
        rst = 1; @(posedge clk); #1; rst = 0;
        m_cnt = 0; m_occ = 0; sb.delete();
        rd_cnt(v); chk(v == 0, "R9 counter after reset", v, 0);
        rd_ts(5'd3, v); chk(v == 0, "R9 ts3 after reset", v, 0);
        chk(ovf_flag == 0, "R9 ovf after reset", {31'd0, ovf_flag}, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule